// File: doc/BRIEF.md
# Indexed Table-Jump Decoder

This block turns a compressed table-jump instruction into an ordinary register jump. The 16-bit instruction carries only an 8-bit slot number. The real destination sits in a word table in memory, whose start is held in a small base register inside the block. When a flagged table-jump arrives, the decoder does four things in turn:

- It works out whether the instruction is a plain jump or a jump that also links.
- It forms the table address from the base and the slot number.
- It fetches one word over a request/grant, response-valid memory port.
- It presents a constructed 32-bit JALR to the issue stage, holding it until the issue stage accepts it.

The result carries a tag that tells the branch unit to ignore any prediction and take the fetched target. A stall output holds back later instructions for the whole sequence.

Software sets the table start through a simple write port. Its low six bits are a mode field that must be zero for table jumps to be legal. If the field is not zero, the decoder makes no memory access and reports the instruction as illegal instead.

Top module: `tblj_decoder`

## Requirements
- R1: After reset, mem_req, out_valid and stall are low and base_value reads zero.
- R2: A write on base_wr_en loads base_wr_data into the base register on the next clock edge, and base_value shows it from then on.
- R3: The slot number is in_instr[9:2]. The fetch address is {base[31:6], 6'b0} plus four times the slot, computed modulo 2^32. mem_req stays high with mem_addr unchanged until the cycle in which mem_gnt is high.
- R4: Slots 0 to 31 are plain jumps: the destination register is x0 and out_link_addr is 0. Slots 32 to 255 link: the destination register is x1 (ra) and out_link_addr is in_pc + 2.
- R5: The emitted instruction is a JALR with imm = 0, rs1 = x0 and funct3 = 0. Its value is 32'h00000067 for a plain jump and 32'h000000E7 for a link. out_target is the fetched word with bit 0 cleared. out_tj_tag is high.
- R6: stall is high from the cycle an instruction is accepted (in_valid and in_tj both high while idle) through the cycle out_ack is seen. It is low in the cycle after that.
- R7: While out_valid is high and out_ack is low, every output field stays unchanged and out_valid stays high.
- R8: If base bits [5:0] are not zero, an accepted table jump makes no memory request. One cycle later it raises out_valid with out_illegal high and out_tj_tag low.
- R9: A new table jump offered while a decode is in progress is ignored. It changes neither the request nor the emitted jump.
- R10: Any number of wait cycles before mem_gnt or before mem_rvalid is tolerated. out_valid rises exactly one cycle after the cycle in which mem_rvalid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_wr_en | input | 1 | Write strobe for the table base register |
| base_wr_data | input | 32 | New table base value (bits [5:0] are the mode field) |
| base_value | output | 32 | Current table base register contents |
| in_valid | input | 1 | Instruction present |
| in_tj | input | 1 | Instruction is a table jump |
| in_instr | input | 16 | Compressed instruction |
| in_pc | input | 32 | Address of the instruction |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Table entry address |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data (jump target) |
| out_valid | output | 1 | Constructed jump available |
| out_instr | output | 32 | Constructed JALR encoding |
| out_target | output | 32 | Jump target, bit 0 cleared |
| out_link_addr | output | 32 | Return address written to ra, or 0 |
| out_tj_tag | output | 1 | Forces the branch unit to take out_target |
| out_illegal | output | 1 | Table jump rejected because the mode field is not zero |
| out_ack | input | 1 | Issue stage accepted the jump |
| stall | output | 1 | Hold back later instructions |

## Verification
The bench probes the slot boundary at 31 and 32. A wrong threshold there would emit x0 where ra belongs, or the reverse. It also uses the highest slot on a base near the top of memory, where a design that ORs the offset into the base instead of adding it, or that drops the carry wrongly, would fetch from the wrong entry. Long grant and data waits, and a held acknowledge, catch a design that drops its request early, emits before the data returns, or lets its outputs drift. A second table jump offered mid-decode, and a base with a nonzero mode field, catch a design that restarts on new input or fetches where it should reject.

// File: rtl/tblj_pkg.sv
package tblj_pkg;
    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_WAIT  = 2'd2,
        ST_ISSUE = 2'd3
    } tj_state_e;

    typedef struct packed {
        tj_state_e         st;
        logic              link;
        logic              bad;
        logic [XLEN-1:0]   addr;
        logic [XLEN-1:0]   ret;
        logic [XLEN-1:0]   tgt;
    } tj_ctx_t;
endpackage

// File: rtl/tblj_base_reg.sv
module tblj_base_reg #(
    parameter int          W      = 32,
    parameter int          MODE_W = 6,
    parameter logic [W-1:0] RST   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] base_q,
    output logic         mode_ok
);
    logic [W-1:0] base_d;

    always_comb begin
        base_d = base_q;
        if (wr_en) base_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= RST;
        else        base_q <= base_d;
    end

    assign mode_ok = (base_q[MODE_W-1:0] == '0);
endmodule

// File: rtl/tblj_addr_gen.sv
module tblj_addr_gen #(
    parameter int W        = 32,
    parameter int IDX_W    = 8,
    parameter int IDX_LSB  = 2,
    parameter int LINK_MIN = 32,
    parameter int MODE_W   = 6,
    parameter int SHIFT    = 2
) (
    input  logic [15:0]  instr,
    input  logic [W-1:0] base,
    output logic         is_link,
    output logic [W-1:0] tbl_addr
);
    logic [IDX_W-1:0] idx;
    logic [W-1:0]     base_al;
    logic [W-1:0]     offs;

    assign idx      = instr[IDX_LSB +: IDX_W];
    assign is_link  = (int'(idx) >= LINK_MIN);
    assign base_al  = {base[W-1:MODE_W], {MODE_W{1'b0}}};
    assign offs     = {{(W-IDX_W){1'b0}}, idx} << SHIFT;
    assign tbl_addr = base_al + offs;
endmodule

// File: rtl/tblj_jump_build.sv
module tblj_jump_build #(
    parameter int W = 32
) (
    input  logic         link,
    input  logic [W-1:0] fetched,
    output logic [31:0]  jalr,
    output logic [W-1:0] target
);
    localparam logic [6:0] OPC_JALR = 7'b1100111;
    localparam logic [4:0] REG_RA   = 5'd1;

    logic [4:0] rd;

    assign rd     = link ? REG_RA : 5'd0;
    assign jalr   = {12'd0, 5'd0, 3'b000, rd, OPC_JALR};
    assign target = {fetched[W-1:1], 1'b0};
endmodule

// File: rtl/tblj_decoder.sv
module tblj_decoder
    import tblj_pkg::*;
#(
    parameter int             IDX_W    = 8,
    parameter int             LINK_MIN = 32,
    parameter int             MODE_W   = 6,
    parameter logic [31:0]    BASE_RST = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        base_wr_en,
    input  logic [31:0] base_wr_data,
    output logic [31:0] base_value,
    input  logic        in_valid,
    input  logic        in_tj,
    input  logic [15:0] in_instr,
    input  logic [31:0] in_pc,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_gnt,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        out_valid,
    output logic [31:0] out_instr,
    output logic [31:0] out_target,
    output logic [31:0] out_link_addr,
    output logic        out_tj_tag,
    output logic        out_illegal,
    input  logic        out_ack,
    output logic        stall
);
    localparam int          SHIFT  = $clog2(XLEN / 8);
    localparam logic [31:0] C_STEP = 32'd2;

    logic            mode_ok;
    logic            dec_link;
    logic [XLEN-1:0] dec_addr;
    logic [31:0]     jalr_w;
    logic [XLEN-1:0] tgt_w;
    logic            accept;
    tj_ctx_t         ctx_d, ctx_q;

    tblj_base_reg #(.W(XLEN), .MODE_W(MODE_W), .RST(BASE_RST)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (base_wr_en),
        .wr_data (base_wr_data),
        .base_q  (base_value),
        .mode_ok (mode_ok)
    );

    tblj_addr_gen #(
        .W(XLEN), .IDX_W(IDX_W), .IDX_LSB(2), .LINK_MIN(LINK_MIN),
        .MODE_W(MODE_W), .SHIFT(SHIFT)
    ) u_addr (
        .instr    (in_instr),
        .base     (base_value),
        .is_link  (dec_link),
        .tbl_addr (dec_addr)
    );

    tblj_jump_build #(.W(XLEN)) u_build (
        .link    (ctx_q.link),
        .fetched (ctx_q.tgt),
        .jalr    (jalr_w),
        .target  (tgt_w)
    );

    assign accept = (ctx_q.st == ST_IDLE) && in_valid && in_tj;

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (accept) begin
                    ctx_d.link = dec_link;
                    ctx_d.addr = dec_addr;
                    ctx_d.ret  = dec_link ? (in_pc + C_STEP) : '0;
                    ctx_d.tgt  = '0;
                    ctx_d.bad  = !mode_ok;
                    ctx_d.st   = mode_ok ? ST_REQ : ST_ISSUE;
                end
            end
            ST_REQ:   if (mem_gnt)    ctx_d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rvalid) begin
                    ctx_d.tgt = mem_rdata;
                    ctx_d.st  = ST_ISSUE;
                end
            end
            ST_ISSUE: if (out_ack)    ctx_d.st = ST_IDLE;
            default:                  ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, link: 1'b0, bad: 1'b0,
                       addr: '0, ret: '0, tgt: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign mem_req       = (ctx_q.st == ST_REQ);
    assign mem_addr      = ctx_q.addr;
    assign out_valid     = (ctx_q.st == ST_ISSUE);
    assign out_instr     = jalr_w;
    assign out_target    = ctx_q.bad ? '0 : tgt_w;
    assign out_link_addr = ctx_q.ret;
    assign out_tj_tag    = out_valid && !ctx_q.bad;
    assign out_illegal   = out_valid && ctx_q.bad;
    assign stall         = accept || (ctx_q.st != ST_IDLE);
endmodule

// File: rtl/tblj_decoder_chk.sv
module tblj_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_gnt,
    input logic        mem_rvalid,
    input logic        out_valid,
    input logic [31:0] out_instr,
    input logic [31:0] out_target,
    input logic [31:0] out_link_addr,
    input logic        out_tj_tag,
    input logic        out_illegal,
    input logic        out_ack,
    input logic        stall
);
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    a_r7_out_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ack) |=> (out_valid && $stable(out_instr) &&
            $stable(out_target) && $stable(out_link_addr) && $stable(out_tj_tag)));

    a_r6_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || out_valid) |-> stall);

    a_r8_illegal_untagged: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_valid && !out_tj_tag));

    a_r5_target_even: assert property (@(posedge clk) disable iff (!rst_n)
        out_tj_tag |-> !out_target[0]);

    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && out_valid));

    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ack) |=> !out_valid);
endmodule

bind tblj_decoder tblj_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .out_valid(out_valid),
    .out_instr(out_instr), .out_target(out_target),
    .out_link_addr(out_link_addr), .out_tj_tag(out_tj_tag),
    .out_illegal(out_illegal), .out_ack(out_ack), .stall(stall)
);

// File: tb/sim_tblj_decoder.sv
`timescale 1ns/1ps
module sim_tblj_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic [31:0] base_value;
    logic        in_valid = 1'b0;
    logic        in_tj = 1'b0;
    logic [15:0] in_instr = '0;
    logic [31:0] in_pc = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid;
    logic [31:0] out_instr;
    logic [31:0] out_target;
    logic [31:0] out_link_addr;
    logic        out_tj_tag;
    logic        out_illegal;
    logic        out_ack = 1'b0;
    logic        stall;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    tblj_decoder u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_instr(input logic [7:0] idx);
        return {3'b101, 3'b000, idx, 2'b10};
    endfunction

    task automatic set_base(input logic [31:0] v);
        @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = v;
        @(negedge clk);
        base_wr_en = 1'b0;
        chk(base_value == v, "R2 base write", base_value, v);
    endtask

    // full legal sequence with chosen wait lengths
    task automatic run_jump(input logic [7:0] idx, input logic [31:0] pc,
                            input logic [31:0] data, input int gw, input int rw,
                            input int aw, input bit intrude);
        logic [31:0] base_al, exp_addr, exp_ret, exp_ins;
        bit link;
        base_al  = {base_value[31:6], 6'b0};
        exp_addr = base_al + {22'd0, idx, 2'b00};
        link     = (idx >= 8'd32);
        exp_ret  = link ? pc + 32'd2 : 32'd0;
        exp_ins  = link ? 32'h000000E7 : 32'h00000067;
        @(negedge clk);
        in_valid = 1'b1; in_tj = 1'b1; in_instr = mk_instr(idx); in_pc = pc;
        #1 chk(stall == 1'b1, "R6 stall on accept", {31'd0, stall}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0; in_tj = 1'b0;
        chk(mem_req == 1'b1, "R3 request raised", {31'd0, mem_req}, 32'd1);
        chk(mem_addr == exp_addr, "R3 table address", mem_addr, exp_addr);
        for (int i = 0; i < gw; i++) begin
            if (intrude && i == 0) begin
                in_valid = 1'b1; in_tj = 1'b1; in_instr = mk_instr(idx ^ 8'h41);
                in_pc = pc + 32'h100;
            end
            @(negedge clk);
            in_valid = 1'b0; in_tj = 1'b0;
            chk(mem_req && mem_addr == exp_addr, "R3 request held", mem_addr, exp_addr);
        end
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        chk(mem_req == 1'b0, "R3 request dropped after grant", {31'd0, mem_req}, 32'd0);
        for (int i = 0; i < rw; i++) begin
            if (intrude) begin
                in_valid = 1'b1; in_tj = 1'b1; in_instr = mk_instr(8'd200);
            end
            @(negedge clk);
            in_valid = 1'b0; in_tj = 1'b0;
            chk(!out_valid && !mem_req && stall, "R10 waiting for data",
                {30'd0, out_valid, mem_req}, 32'd0);
        end
        mem_rvalid = 1'b1; mem_rdata = data;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
        chk(out_valid == 1'b1, "R10 out one cycle after data", {31'd0, out_valid}, 32'd1);
        chk(out_instr == exp_ins, "R5 jalr encoding / R4 rd", out_instr, exp_ins);
        chk(out_target == {data[31:1], 1'b0}, "R5 target", out_target, {data[31:1], 1'b0});
        chk(out_link_addr == exp_ret, "R4 link address", out_link_addr, exp_ret);
        chk(out_tj_tag && !out_illegal, "R5 tag set", {30'd0, out_tj_tag, out_illegal}, 32'd2);
        for (int i = 0; i < aw; i++) begin
            @(negedge clk);
            chk(out_valid && out_target == {data[31:1], 1'b0} && out_instr == exp_ins,
                "R7 output held", out_target, {data[31:1], 1'b0});
        end
        out_ack = 1'b1;
        #1 chk(stall == 1'b1, "R6 stall through ack", {31'd0, stall}, 32'd1);
        @(negedge clk);
        out_ack = 1'b0;
        chk(!out_valid && !stall && !mem_req, "R6 release after ack / R9 no restart",
            {29'd0, out_valid, stall, mem_req}, 32'd0);
    endtask

    task automatic t_reset;
        chk(!mem_req && !out_valid && !stall, "R1 reset outputs",
            {29'd0, mem_req, out_valid, stall}, 32'd0);
        chk(base_value == 32'd0, "R1 reset base", base_value, 32'd0);
    endtask

    task automatic t_illegal;
        set_base(32'h0000_2005);
        @(negedge clk);
        in_valid = 1'b1; in_tj = 1'b1; in_instr = mk_instr(8'd7); in_pc = 32'h400;
        #1 chk(mem_req == 1'b0, "R8 no request", {31'd0, mem_req}, 32'd0);
        @(negedge clk);
        in_valid = 1'b0; in_tj = 1'b0;
        chk(mem_req == 1'b0, "R8 still no request", {31'd0, mem_req}, 32'd0);
        chk(out_valid && out_illegal && !out_tj_tag, "R8 illegal flagged",
            {29'd0, out_valid, out_illegal, out_tj_tag}, 32'd6);
        out_ack = 1'b1;
        @(negedge clk);
        out_ack = 1'b0;
        chk(!out_valid && !stall, "R8 release", {30'd0, out_valid, stall}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        set_base(32'h0000_1000);
        run_jump(8'd5,   32'h0000_0200, 32'h0000_1337, 0, 0, 0, 1'b0); // R4 plain
        run_jump(8'd31,  32'h0000_0300, 32'h0000_2000, 2, 1, 1, 1'b0); // R4 boundary low
        run_jump(8'd32,  32'h0000_0400, 32'h0000_3001, 1, 3, 2, 1'b0); // R4 boundary link
        set_base(32'hFFFF_FFC0);
        run_jump(8'd255, 32'hFFFF_FFFE, 32'h8000_0003, 4, 5, 3, 1'b0); // R3 wrap, R4 wrap
        set_base(32'h0001_0040);
        run_jump(8'd100, 32'h0000_1000, 32'h0000_4444, 3, 2, 1, 1'b1); // R9 intrusion
        t_illegal();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule